// File: doc/BRIEF.md
# Buffered-Compare PWM Timer Core

This block is a 16-bit timer whose counting range is bounded by a period register. It counts either in a triangle (up to the period, then back down to zero) or in a sawtooth (up to the period, then cleared to zero). A set of general compare channels is checked against the counter on every counting step, and each equality raises a one-cycle match pulse. The period match and the underflow at the bottom of the triangle also raise pulses. Together these form the timing reference for a PWM generator.

Software never writes an active compare value directly. Every compare register, the period register included, sits behind a shadow buffer. While the timer runs, buffer contents are copied into the active registers only on a reload event, which is a period match or an underflow. This means a value written halfway through a cycle cannot cut a PWM period short. Two separate enable bits gate the copy: one for the general channels and one for the period register. While the timer is stopped, the active registers follow their buffers one clock after a write, so the first period after start-up uses the values just written.

Top module: `pwm_shadow_timer`

## Requirements
- R1: After reset the counter is 0, the direction is up (`down_o` = 0), and every buffer and every active compare register reads 0.
- R2: In triangle mode (`saw_mode` = 0) the counter rises by one per counting step.
  - On the step where it equals the active period while rising, the next value is one lower and `down_o` becomes 1.
  - On a falling step where it is 0, `udf_o` pulses, the direction returns to up, and the next value is 1. If the period is 0, the next value stays 0.
- R3: In sawtooth mode (`saw_mode` = 1) the counter rises by one per step and is cleared to 0 on the step after a period match. `udf_o` never pulses and `down_o` stays 0.
- R4: On a counting step, `ch_match_o[i]` is high when the counter equals channel i's active value, in either direction. `per_match_o` is high when the counter equals the active period while counting up.
- R5: A counting step is a cycle with `run_en` = 1 and `cnt_en` = 1. On any other cycle the counter and direction hold, and `per_match_o`, `udf_o` and `ch_match_o` are all 0, even when the values are equal.
- R6: While `run_en` = 1, the active registers change only on the clock edge that ends a step on which `per_match_o` or `udf_o` is high. On that edge they take the buffer contents.
- R7: On a running reload, all channel buffers copy only if `ch_xfer_en` = 1, and the period buffer copies only if `per_xfer_en` = 1. The two enables act independently.
- R8: A buffer write on the same edge as a reload copy is stored in the buffer. The active register takes the buffer's earlier value, and the new value reaches it at the next reload event.
- R9: While `run_en` = 0, every active register takes its buffer's value on each clock edge, whatever the enable bits are. A write therefore becomes active one cycle after the edge that stores it.
- R10: Register addresses:
  - 0 is the period buffer.
  - 1 to N_CH are the channel buffers.
  - N_CH+1 is the active period.
  - N_CH+2 to 2·N_CH+1 are the active channels.
  - 2·N_CH+2 reads the counter.
  - Writes to addresses 0 to N_CH store a full 16-bit value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Timer running when high |
| cnt_en | input | 1 | Count-clock enable, one counting step per high cycle |
| saw_mode | input | 1 | 1 = sawtooth, 0 = triangle |
| ch_xfer_en | input | 1 | Enables buffer copy for the general channels |
| per_xfer_en | input | 1 | Enables buffer copy for the period register |
| wr_en | input | 1 | Buffer write strobe |
| wr_addr | input | ADDR_W | Buffer write address |
| wr_data | input | CNT_W | Buffer write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | CNT_W | Read data (combinational) |
| cnt_o | output | CNT_W | Current counter value |
| down_o | output | 1 | Counting direction, 1 = down |
| per_match_o | output | 1 | Period match pulse |
| udf_o | output | 1 | Underflow pulse (triangle mode) |
| ch_match_o | output | N_CH | Per-channel compare match pulses |

## Verification
A vector table runs the counter through both modes with periods of 0, 1, 3, 5 and 7. It uses compare values at zero, in the middle, at the period and beyond it. For each pattern it records the step of the first period match, the first underflow and the first channel match, plus the number of period matches in twenty steps. These records separate a triangle from a sawtooth, an off-by-one turnaround from a correct one, and a degenerate zero period from a normal one.

Directed sequences then cover the following cases:
- writing a buffer mid-period, to show that only a reload event moves the value;
- clearing one enable, to show that the channel and period copies are gated apart;
- writing on the reload edge itself, to show which value wins;
- stopping the count clock while values are equal;
- writing while stopped, to show the one-cycle follow.

// File: rtl/pst_pkg.sv
package pst_pkg;

    localparam int DEF_CNT_W = 16;

    typedef enum logic {
        MODE_TRI = 1'b0,
        MODE_SAW = 1'b1
    } mode_e;

endpackage

// File: rtl/pst_counter.sv
module pst_counter
    import pst_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             cnt_en,
    input  mode_e            mode,
    input  logic [CNT_W-1:0] per_val,
    output logic [CNT_W-1:0] cnt,
    output logic             down,
    output logic             per_hit,
    output logic             udf
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             down;
    } ctr_s;

    ctr_s st_d, st_q;
    logic step, at_top, at_zero;

    always_comb begin
        step    = run_en && cnt_en;
        at_top  = (st_q.cnt == per_val);
        at_zero = (st_q.cnt == '0);
        per_hit = step && at_top && !st_q.down;
        udf     = step && (mode == MODE_TRI) && st_q.down && at_zero;

        st_d = st_q;
        if (step) begin
            if (mode == MODE_SAW) begin
                st_d.down = 1'b0;
                st_d.cnt  = at_top ? '0 : st_q.cnt + ONE;
            end else if (st_q.down) begin
                if (at_zero) begin
                    st_d.down = 1'b0;
                    st_d.cnt  = (per_val == '0) ? '0 : ONE;
                end else begin
                    st_d.cnt  = st_q.cnt - ONE;
                end
            end else if (at_top) begin
                st_d.down = 1'b1;
                st_d.cnt  = at_zero ? '0 : st_q.cnt - ONE;
            end else begin
                st_d.cnt  = st_q.cnt + ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt  = st_q.cnt;
    assign down = st_q.down;

    AST_SAW_STAYS_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && cnt_en && mode == MODE_SAW) |=> !down); // R3
    AST_SAW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (per_hit && mode == MODE_SAW) |=> (cnt == '0)); // R3
    AST_TOP_TURNS: assert property (@(posedge clk) disable iff (!rst_n)
        (per_hit && mode == MODE_TRI) |=> down); // R2
    AST_UDF_TURNS: assert property (@(posedge clk) disable iff (!rst_n)
        udf |=> !down); // R2
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(run_en && cnt_en) |=> ($stable(cnt) && $stable(down))); // R5

endmodule

// File: rtl/pst_cmp_bank.sv
module pst_cmp_bank
    import pst_pkg::*;
#(
    parameter int N_CH   = 4,
    parameter int CNT_W  = DEF_CNT_W,
    parameter int ADDR_W = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        run_en,
    input  logic                        ch_xfer_en,
    input  logic                        per_xfer_en,
    input  logic                        reload,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [CNT_W-1:0]            wr_data,
    output logic [N_CH:0][CNT_W-1:0]    bufs,
    output logic [N_CH:0][CNT_W-1:0]    acts
);

    localparam int N_REG = N_CH + 1;

    typedef struct packed {
        logic [N_CH:0][CNT_W-1:0] bufs;
        logic [N_CH:0][CNT_W-1:0] acts;
    } bank_s;

    bank_s bk_d, bk_q;
    logic  gate;

    always_comb begin
        bk_d = bk_q;
        gate = 1'b0;
        for (int i = 0; i < N_REG; i++) begin
            if (wr_en && wr_addr == ADDR_W'(i)) begin
                bk_d.bufs[i] = wr_data;
            end
            gate = (i == 0) ? per_xfer_en : ch_xfer_en;
            if (!run_en || (reload && gate)) begin
                bk_d.acts[i] = bk_q.bufs[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bk_q <= '0;
        else        bk_q <= bk_d;
    end

    assign bufs = bk_q.bufs;
    assign acts = bk_q.acts;

    AST_ACTIVE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !reload) |=> $stable(acts)); // R6
    AST_STOPPED_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (acts == $past(bufs))); // R9

endmodule

// File: rtl/pst_match.sv
module pst_match
    import pst_pkg::*;
#(
    parameter int N_CH  = 4,
    parameter int CNT_W = DEF_CNT_W
) (
    input  logic                        run_en,
    input  logic                        cnt_en,
    input  logic [CNT_W-1:0]            cnt,
    input  logic [N_CH-1:0][CNT_W-1:0]  cmp,
    output logic [N_CH-1:0]             hit
);

    for (genvar g = 0; g < N_CH; g++) begin : g_cmp
        assign hit[g] = run_en && cnt_en && (cnt == cmp[g]);
    end

endmodule

// File: rtl/pwm_shadow_timer.sv
module pwm_shadow_timer
    import pst_pkg::*;
#(
    parameter  int N_CH   = 4,
    parameter  int CNT_W  = DEF_CNT_W,
    localparam int ADDR_W = $clog2(2 * N_CH + 3)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              cnt_en,
    input  logic              saw_mode,
    input  logic              ch_xfer_en,
    input  logic              per_xfer_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              down_o,
    output logic              per_match_o,
    output logic              udf_o,
    output logic [N_CH-1:0]   ch_match_o
);

    localparam int CNT_ADDR = 2 * N_CH + 2;

    mode_e                     mode;
    logic [CNT_W-1:0]          cnt;
    logic                      down, per_hit, udf;
    logic [N_CH:0][CNT_W-1:0]  bufs, acts;

    assign mode = saw_mode ? MODE_SAW : MODE_TRI;

    pst_counter #(.CNT_W(CNT_W)) ctr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_en  (run_en),
        .cnt_en  (cnt_en),
        .mode    (mode),
        .per_val (acts[0]),
        .cnt     (cnt),
        .down    (down),
        .per_hit (per_hit),
        .udf     (udf)
    );

    pst_cmp_bank #(.N_CH(N_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) bank_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_en      (run_en),
        .ch_xfer_en  (ch_xfer_en),
        .per_xfer_en (per_xfer_en),
        .reload      (per_hit || udf),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .bufs        (bufs),
        .acts        (acts)
    );

    pst_match #(.N_CH(N_CH), .CNT_W(CNT_W)) match_i (
        .run_en (run_en),
        .cnt_en (cnt_en),
        .cnt    (cnt),
        .cmp    (acts[N_CH:1]),
        .hit    (ch_match_o)
    );

    always_comb begin
        rd_data = '0;
        for (int i = 0; i <= N_CH; i++) begin
            if (rd_addr == ADDR_W'(i))            rd_data = bufs[i];
            if (rd_addr == ADDR_W'(N_CH + 1 + i)) rd_data = acts[i];
        end
        if (rd_addr == ADDR_W'(CNT_ADDR)) rd_data = cnt;
    end

    assign cnt_o       = cnt;
    assign down_o      = down;
    assign per_match_o = per_hit;
    assign udf_o       = udf;

endmodule

// File: tb/pwm_shadow_timer_tb_top.sv
module pwm_shadow_timer_tb_top;

    localparam int N_CH = 4;
    localparam int AW   = 4;
    localparam int NV   = 6;
    // mode, period, ch0 value, first per step, first udf step, first ch0 step, per count in 20 steps
    localparam int VEC [NV][7] = '{
        '{0, 5, 2, 5,  10,  2, 2},
        '{1, 5, 2, 5,  -1,  2, 3},
        '{0, 1, 0, 1,   2,  0, 10},
        '{0, 0, 0, 0,   1,  0, 10},
        '{1, 3, 7, 3,  -1, -1, 5},
        '{0, 7, 7, 7,  14,  7, 1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_en = 0, cnt_en = 0, saw_mode = 0, ch_xfer_en = 0, per_xfer_en = 0, wr_en = 0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [15:0] wr_data = '0, rd_data, cnt_o;
    logic down_o, per_match_o, udf_o;
    logic [N_CH-1:0] ch_match_o;

    int n_cmp = 0, n_bad = 0;

    always #5 clk = ~clk;

    pwm_shadow_timer #(.N_CH(N_CH)) dut_i (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .cnt_en(cnt_en), .saw_mode(saw_mode),
        .ch_xfer_en(ch_xfer_en), .per_xfer_en(per_xfer_en), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .cnt_o(cnt_o), .down_o(down_o),
        .per_match_o(per_match_o), .udf_o(udf_o), .ch_match_o(ch_match_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic step_wr(input int a, input int d);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = 16'(d);
        step();
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        rd_addr = AW'(a);
        #1;
        v = int'(rd_data);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; run_en = 0; cnt_en = 0; saw_mode = 0;
        ch_xfer_en = 0; per_xfer_en = 0; wr_en = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int v, f_per, f_udf, f_ch, n_per;

        // R1: reset state, read through the R10 address map
        do_reset();
        for (int a = 0; a <= 2 * N_CH + 2; a++) begin
            rd(a, v);
            chk($sformatf("R1 R10 reg %0d after reset", a), v, 0);
        end
        chk("R1 direction after reset", int'(down_o), 0);

        // Table walk: R2 R3 R4
        for (int k = 0; k < NV; k++) begin
            do_reset();
            saw_mode = VEC[k][0][0];
            ch_xfer_en = 1; per_xfer_en = 1;
            step_wr(0, VEC[k][1]);
            step_wr(1, VEC[k][2]);
            step();
            run_en = 1; cnt_en = 1;
            #1;
            f_per = -1; f_udf = -1; f_ch = -1; n_per = 0;
            for (int s = 0; s < 20; s++) begin
                if (per_match_o) begin
                    n_per++;
                    if (f_per < 0) f_per = s;
                end
                if (udf_o && f_udf < 0) f_udf = s;
                if (ch_match_o[0] && f_ch < 0) f_ch = s;
                step();
            end
            chk($sformatf("R2 R3 vec%0d first period match", k), f_per, VEC[k][3]);
            chk($sformatf("R2 R3 vec%0d first underflow", k), f_udf, VEC[k][4]);
            chk($sformatf("R4 vec%0d first ch0 match", k), f_ch, VEC[k][5]);
            chk($sformatf("R2 R3 vec%0d period matches in 20", k), n_per, VEC[k][6]);
        end

        // R5: no stepping and no pulses while cnt_en is low, even with equal values
        do_reset();
        run_en = 1; cnt_en = 0;
        #1;
        chk("R5 ch1 match gated", int'(ch_match_o[1]), 0);
        chk("R5 period match gated", int'(per_match_o), 0);
        step(); step(); step();
        chk("R5 counter held", int'(cnt_o), 0);
        cnt_en = 1;
        #1;
        chk("R4 ch1 match at equal value", int'(ch_match_o[1]), 1);
        chk("R4 period match at zero period", int'(per_match_o), 1);

        // R6: running write moves to active only at the reload event
        do_reset();
        ch_xfer_en = 1; per_xfer_en = 1;
        step_wr(0, 5);
        step_wr(1, 9);
        step();
        run_en = 1; cnt_en = 1;
        #1;
        step(); step();
        step_wr(1, 3);
        rd(N_CH + 2, v);
        chk("R6 active ch0 before event", v, 9);
        step(); step();
        chk("R6 period match at step 5", int'(per_match_o), 1);
        rd(N_CH + 2, v);
        chk("R6 active ch0 still old", v, 9);
        step();
        rd(N_CH + 2, v);
        chk("R6 active ch0 after event", v, 3);
        rd(1, v);
        chk("R10 ch0 buffer readback", v, 3);
        rd(2 * N_CH + 2, v);
        chk("R10 counter readback", v, 4);

        // R7: separate enables
        do_reset();
        ch_xfer_en = 1; per_xfer_en = 1;
        step_wr(0, 3);
        step_wr(1, 1);
        step();
        ch_xfer_en = 0;
        run_en = 1; cnt_en = 1;
        #1;
        step_wr(1, 2);
        step_wr(0, 2);
        step(); step();
        rd(N_CH + 2, v);
        chk("R7 channel copy blocked", v, 1);
        rd(N_CH + 1, v);
        chk("R7 period copy allowed", v, 2);

        // R8: write on the reload edge
        do_reset();
        saw_mode = 1; ch_xfer_en = 1; per_xfer_en = 1;
        step_wr(0, 4);
        step_wr(1, 0);
        step();
        run_en = 1; cnt_en = 1;
        #1;
        step();
        step_wr(1, 5);
        step(); step();
        chk("R8 period match at step 4", int'(per_match_o), 1);
        step_wr(1, 7);
        rd(N_CH + 2, v);
        chk("R8 active takes earlier buffer", v, 5);
        rd(1, v);
        chk("R8 buffer keeps same-edge write", v, 7);
        step(); step(); step(); step(); step();
        rd(N_CH + 2, v);
        chk("R8 same-edge write at next event", v, 7);

        // R9: stopped follow, enables cleared
        do_reset();
        step_wr(2, 16'h1234);
        rd(N_CH + 3, v);
        chk("R9 active ch1 one edge after write", v, 0);
        step();
        rd(N_CH + 3, v);
        chk("R9 active ch1 follows buffer", v, 16'h1234);

        finish_run();
    end

endmodule